// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that software drives through a small 32-bit register window. Words written to a transmit data port go into a transmit FIFO. The shift engine takes each word from that FIFO and sends it on MOSI while clocking SCK. In the same bit times it captures the returning bits and pushes each finished word into a receive FIFO, which software reads from a receive data port. The data width is a build parameter (8, 16 or 32 bits), and data is right-aligned in the 32-bit ports. The SCK half-period is a build parameter in system clocks and cannot be changed at run time.

Software selects clock polarity, sampling phase, bit order and an internal loopback path in a control word. A hold bit in that word lets software queue a whole burst before any bit moves. When the hold bit is cleared, the queued words go out with no idle clocks between them. A slave-select register drives the active-low select pins. In manual mode the pins follow the register all the time. In automatic mode the pins follow the register only while a word is shifting. Level and pulse event outputs go to a separate interrupt block. Each FIFO can be emptied by writing a self-clearing bit.

Top module: `spim_core`

## Requirements
- R1: After reset the control word reads 0x000, status reads 0x005, the select register reads all ones, SCK is low and every select pin is high.
- R2: Control bits 0 loopback, 1 enable, 2 master, 3 CPOL, 4 CPHA, 7 manual select, 8 hold and 9 LSB-first read back as written at offset 0x60. Bits 5 and 6 always read back 0.
- R3: Status at 0x64 has bit 0 RX empty, bit 1 RX full, bit 2 TX done, bit 3 TX full. TX full is set exactly when DEPTH words are queued. A write to the port at 0x68 while the TX FIFO is full drops the word, and evt_tx_overflow is high in the next cycle.
- R4: While hold (bit 8) is set, queued words never start shifting. After hold is cleared, the first SCK edge comes CLK_DIV cycles after the word is taken, and all queued words go out with no idle cycle between words.
- R5: Words go out MSB first. With bit 9 set they go out LSB first. Received words are assembled in the same order.
- R6: SCK idles at CPOL. With CPHA=0, MOSI is valid on the leading edge of each bit. With CPHA=1, MOSI is valid on the trailing edge.
- R7: With loopback set, the received word equals the sent word, whatever the level of the MISO pin.
- R8: With loopback clear, the received bits come from MISO, right-aligned at offset 0x6C with the upper bits zero.
- R9: Status bit 2 is set only when the TX FIFO is empty and no word is shifting, so that every received word is already readable.
- R10: When a word completes while the RX FIFO is full, that word is dropped and evt_rx_overrun is high in the next cycle. The words already stored are kept.
- R11: In manual mode (bit 7) ss_n equals the select register at offset 0x70. In automatic mode ss_n is all ones when idle and equals the register while a word shifts.
- R12: Consecutive SCK edges during shifting are exactly CLK_DIV system clocks apart.
- R13: No word starts shifting while enable (bit 1) or master (bit 2) is clear.
- R14: Writing 1 to control bit 5 empties the TX FIFO. Writing 1 to bit 6 empties the RX FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |
| evt_tx_done | output | 1 | Level: TX FIFO empty and shifter idle |
| evt_rx_full | output | 1 | Level: RX FIFO full |
| evt_tx_overflow | output | 1 | Pulse: a TX write was dropped |
| evt_rx_overrun | output | 1 | Pulse: a received word was dropped |

## Verification
The main loop sends one word in loopback for each of the eight CPOL, CPHA and bit-order combinations while MISO is held high. A bench monitor samples MOSI on the edge the mode defines. This separates the phase and order settings from each other, and the mix of zeros and ones in the words catches any leak from the MISO pin. Separate non-loopback transfers with MISO at 1 and then 0 show where the receive bits come from. A burst of DEPTH held words is counted edge by edge at the exact cycle where the last edge must fall, which exposes any idle cycle between words. A burst of DEPTH+1 words without reads exercises the overrun drop.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h60;
  localparam logic [7:0] ADDR_STAT = 8'h64;
  localparam logic [7:0] ADDR_TXD  = 8'h68;
  localparam logic [7:0] ADDR_RXD  = 8'h6C;
  localparam logic [7:0] ADDR_SSEL = 8'h70;

  localparam int CTRL_W   = 10;
  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_MANSS = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;

  // bits that are stored; the two FIFO clear bits are strobes only
  localparam logic [CTRL_W-1:0] CTRL_KEEP =
    ~((CTRL_W'(1) << CB_TXCLR) | (CTRL_W'(1) << CB_RXCLR));

  typedef struct packed {
    logic lsb;
    logic hold;
    logic man_ss;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
    logic loop;
  } spim_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_TOP = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == PTR_TOP) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_TOP) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W   = 8,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_word,
  output logic         tx_pop,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb,
  input  logic         loop,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         rx_push,
  output logic [W-1:0] rx_word
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW = $clog2(2 * W);
  localparam logic [CW-1:0] CNT_TOP   = CW'(DIV - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(2 * W - 1);

  logic          busy_q, busy_d, phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] eidx_q, eidx_d;
  logic [W-1:0]  tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d;
  logic [W-1:0]  tx_rev, rx_next, rx_cap, rx_rev;
  logic          edge_now, last_edge, load, sample_now, shift_now, in_bit;

  // bit reversal for LSB-first order, one wire per bit
  always_comb begin
    for (int i = 0; i < W; i++) begin
      tx_rev[i] = tx_word[W-1-i];
      rx_rev[i] = rx_cap[W-1-i];
    end
  end

  assign edge_now   = busy_q && (cnt_q == CNT_TOP);
  assign last_edge  = edge_now && (eidx_q == EDGE_LAST);
  assign load       = (!busy_q || last_edge) && go && tx_avail;
  // CPHA=0 samples on even edges, CPHA=1 on odd edges
  assign sample_now = edge_now && (eidx_q[0] == cpha);
  assign shift_now  = edge_now && !last_edge && (eidx_q[0] != cpha) && (eidx_q != '0);

  assign mosi    = busy_q ? tx_sh_q[W-1] : 1'b0;
  assign in_bit  = loop ? mosi : miso;
  assign rx_next = {rx_sh_q[W-2:0], in_bit};
  assign rx_cap  = cpha ? rx_next : rx_sh_q;

  assign sck     = cpol ^ phase_q;
  assign busy    = busy_q;
  assign tx_pop  = load;
  assign rx_push = last_edge;
  assign rx_word = lsb ? rx_rev : rx_cap;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    eidx_d  = eidx_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    if (busy_q) begin
      cnt_d = edge_now ? '0 : cnt_q + 1'b1;
      if (edge_now) begin
        phase_d = ~phase_q;
        eidx_d  = eidx_q + 1'b1;
      end
      if (shift_now)  tx_sh_d = {tx_sh_q[W-2:0], 1'b0};
      if (sample_now) rx_sh_d = rx_next;
      if (last_edge)  busy_d  = 1'b0;
    end
    if (load) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      cnt_d   = '0;
      eidx_d  = '0;
      tx_sh_d = lsb ? tx_rev : tx_word;
      rx_sh_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      eidx_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      eidx_q  <= eidx_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int W   = 8,
  parameter int NSS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           st_rx_empty,
  input  logic           st_rx_full,
  input  logic           st_tx_done,
  input  logic           st_tx_full,
  input  logic [W-1:0]   rx_head,
  output spim_cfg_t      cfg,
  output logic           tx_push,
  output logic [W-1:0]   tx_wdata,
  output logic           rx_pop,
  output logic           tx_clr,
  output logic           rx_clr,
  output logic [NSS-1:0] ss_q
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NSS-1:0]    ss_d;
  logic              ctrl_we, ss_we;

  assign ctrl_we  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign ss_we    = bus_sel && bus_wr && (bus_addr == ADDR_SSEL);
  assign tx_push  = bus_sel && bus_wr && (bus_addr == ADDR_TXD);
  assign tx_wdata = bus_wdata[W-1:0];
  assign rx_pop   = bus_sel && !bus_wr && (bus_addr == ADDR_RXD) && !st_rx_empty;
  assign tx_clr   = ctrl_we && bus_wdata[CB_TXCLR];
  assign rx_clr   = ctrl_we && bus_wdata[CB_RXCLR];

  assign ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
  assign ss_d   = bus_wdata[NSS-1:0];

  assign cfg.loop   = ctrl_q[CB_LOOP];
  assign cfg.enable = ctrl_q[CB_EN];
  assign cfg.master = ctrl_q[CB_MST];
  assign cfg.cpol   = ctrl_q[CB_CPOL];
  assign cfg.cpha   = ctrl_q[CB_CPHA];
  assign cfg.man_ss = ctrl_q[CB_MANSS];
  assign cfg.hold   = ctrl_q[CB_HOLD];
  assign cfg.lsb    = ctrl_q[CB_LSB];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata = 32'(ctrl_q);
      ADDR_STAT: bus_rdata = {28'd0, st_tx_full, st_tx_done, st_rx_full, st_rx_empty};
      ADDR_RXD:  bus_rdata = 32'(rx_head);
      ADDR_SSEL: bus_rdata = 32'(ss_q);
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ss_q   <= '1;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (ss_we)   ss_q   <= ss_d;
    end
  end
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int DIV   = 2,
  parameter int NSS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n,
  output logic           evt_tx_done,
  output logic           evt_rx_full,
  output logic           evt_tx_overflow,
  output logic           evt_rx_overrun
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  spim_cfg_t      cfg;
  logic           tx_push, tx_pop, tx_clr, tx_empty, tx_full;
  logic           rx_push, rx_pop, rx_clr, rx_empty, rx_full;
  logic [W-1:0]   tx_wdata, tx_head, rx_word, rx_head;
  logic [NSS-1:0] ss_q;
  logic           sh_busy, go, tx_done;
  logic           ovf_d, ovr_d, ovf_q, ovr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign go      = cfg.enable && cfg.master && !cfg.hold;
  assign tx_done = tx_empty && !sh_busy;

  spim_regs #(.W(W), .NSS(NSS)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_rx_empty(rx_empty), .st_rx_full(rx_full),
    .st_tx_done(tx_done), .st_tx_full(tx_full),
    .rx_head(rx_head), .cfg(cfg),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .ss_q(ss_q)
  );

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n), .clr(tx_clr),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int_n), .clr(rx_clr),
    .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spim_shift #(.W(W), .DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .go(go),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .cpol(cfg.cpol), .cpha(cfg.cpha), .lsb(cfg.lsb), .loop(cfg.loop),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(sh_busy),
    .rx_push(rx_push), .rx_word(rx_word)
  );

  assign ss_n = (cfg.man_ss || sh_busy) ? ss_q : '1;

  assign ovf_d = tx_push && tx_full;
  assign ovr_d = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      ovr_q <= ovr_d;
    end
  end

  assign evt_tx_done     = tx_done;
  assign evt_rx_full     = rx_full;
  assign evt_tx_overflow = ovf_q;
  assign evt_rx_overrun  = ovr_q;
endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk #(
  parameter int DIV = 2,
  parameter int NSS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck,
  input logic           cpol,
  input logic           busy,
  input logic [NSS-1:0] ss_n,
  input logic           man_ss,
  input logic           hold,
  input logic           enable,
  input logic           master,
  input logic           tx_full,
  input logic           tx_empty,
  input logic           tx_push,
  input logic           evt_tx_overflow,
  input logic           rx_push,
  input logic           rx_full,
  input logic           evt_rx_overrun
);
  localparam int GW = $clog2(DIV + 2);
  localparam logic [GW-1:0] GMAX = GW'(DIV + 1);
  localparam logic [GW-1:0] GMIN = GW'(DIV - 1);

  logic          sck_prev_q, busy_prev_q, sck_moved;
  logic [GW-1:0] still_q;

  assign sck_moved = (sck != sck_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q  <= 1'b0;
      busy_prev_q <= 1'b0;
      still_q     <= GMAX;
    end else begin
      sck_prev_q  <= sck;
      busy_prev_q <= busy;
      if (sck_moved)          still_q <= '0;
      else if (still_q != GMAX) still_q <= still_q + 1'b1;
    end
  end

  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  assert_auto_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !man_ss) |-> (&ss_n));

  assert_hold_keeps_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> !busy);

  assert_gate_keeps_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((!enable || !master) && !busy) |=> !busy);

  assert_half_period_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_prev_q && sck_moved) |-> (still_q >= GMIN));

  assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty);

  assert_overflow_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full) |=> evt_tx_overflow);

  assert_overrun_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> evt_rx_overrun);
endmodule

bind spim_core spim_core_chk #(.DIV(DIV), .NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cpol(cfg.cpol), .busy(sh_busy),
  .ss_n(ss_n), .man_ss(cfg.man_ss), .hold(cfg.hold), .enable(cfg.enable),
  .master(cfg.master), .tx_full(tx_full), .tx_empty(tx_empty),
  .tx_push(tx_push), .evt_tx_overflow(evt_tx_overflow),
  .rx_push(rx_push), .rx_full(rx_full), .evt_rx_overrun(evt_rx_overrun)
);

// File: tb/spim_core_test.sv
module spim_core_test;
  localparam int W = 8, DEPTH = 4, DIV = 2, NSS = 4;
  localparam logic [31:0] C_LOOP = 32'h001, C_EN = 32'h002, C_MST = 32'h004,
    C_CPOL = 32'h008, C_CPHA = 32'h010, C_TXR = 32'h020, C_RXR = 32'h040,
    C_MAN = 32'h080, C_HOLD = 32'h100, C_LSB = 32'h200;
  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
    A_RXD = 8'h6C, A_SSEL = 8'h70;
  // {cpol, cpha, lsb, word}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'hA5}, {3'b010, 8'h3C}, {3'b100, 8'h81}, {3'b110, 8'h0F},
    {3'b001, 8'hC1}, {3'b011, 8'h5A}, {3'b101, 8'hE7}, {3'b111, 8'h12}};

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0, miso = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, evt_tx_done, evt_rx_full, evt_tx_overflow, evt_rx_overrun;
  logic [NSS-1:0] ss_n;
  int checks = 0, errors = 0;

  // monitor state (written only by the monitor, except the m_cpol/m_cpha/m_track settings)
  logic m_cpol = 1'b0, m_cpha = 1'b0, m_track = 1'b0;
  logic m_sck_prev = 1'b0, m_mosi_prev = 1'b0;
  logic [31:0] m_cap = '0;
  int m_edges = 0, m_gap = 1000, m_min_gap = 1000, m_ovr = 0, cycles = 0;

  spim_core #(.W(W), .DEPTH(DEPTH), .DIV(DIV), .NSS(NSS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .evt_tx_done(evt_tx_done), .evt_rx_full(evt_rx_full),
    .evt_tx_overflow(evt_tx_overflow), .evt_rx_overrun(evt_rx_overrun));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (sck !== m_sck_prev) begin
      m_edges = m_edges + 1;
      if (m_track && m_gap < m_min_gap) m_min_gap = m_gap;
      m_gap = 1;
      if (((sck != m_cpol) ? 1'b1 : 1'b0) ^ m_cpha) m_cap = {m_cap[30:0], m_mosi_prev};
    end else if (m_gap < 1000) m_gap = m_gap + 1;
    if (evt_rx_overrun === 1'b1) m_ovr = m_ovr + 1;
    m_sck_prev = sck;
    m_mosi_prev = mosi;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, s);
      if (s[2]) return;
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h5);
    rd(A_SSEL, d); chk("R1 select reg", d, 32'hF);
    chk("R1 sck/ss_n", {27'd0, sck, ss_n}, {27'd0, 1'b0, 4'hF});

    // R2: readback, clear bits read zero
    wr(A_CTRL, 32'h3FF); rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h39F);
    wr(A_CTRL, 32'h0);
    repeat (4) @(negedge clk);

    // Vector loop: R5, R6, R7 (MISO held high), R12
    miso = 1'b1;
    m_track = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic cp, ch, ls;
      logic [7:0] w;
      {cp, ch, ls, w} = VEC[v];
      wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD | (cp ? C_CPOL : 0) | (ch ? C_CPHA : 0) | (ls ? C_LSB : 0));
      m_cpol = cp; m_cpha = ch;
      repeat (3) @(negedge clk); #1;
      chk("R6 sck idles at CPOL", {31'd0, sck}, {31'd0, cp});
      wr(A_TXD, {24'd0, w});
      base = m_edges;
      wr(A_CTRL, C_EN | C_MST | C_LOOP | (cp ? C_CPOL : 0) | (ch ? C_CPHA : 0) | (ls ? C_LSB : 0));
      wait_done();
      repeat (2) @(negedge clk); #1;
      chk("R6 edge count per word", m_edges - base, 2 * W);
      chk("R5 R6 mosi stream", {24'd0, m_cap[7:0]}, {24'd0, ls ? rev8(w) : w});
      rd(A_RXD, d); chk("R7 loopback word ignores miso", d, {24'd0, w});
    end
    m_track = 1'b0;
    chk("R12 half period", m_min_gap, DIV);
    m_cpol = 1'b0; m_cpha = 1'b0;

    // R8: data from MISO, right-aligned
    wr(A_CTRL, C_EN | C_MST);
    miso = 1'b1; wr(A_TXD, 32'h00); wait_done();
    rd(A_RXD, d); chk("R8 miso high", d, 32'h000000FF);
    miso = 1'b0; wr(A_TXD, 32'hFF); wait_done();
    rd(A_RXD, d); chk("R8 miso low", d, 32'h0);

    // R3/R4: fill under hold, overflow, burst timing
    wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD);
    for (int i = 0; i < DEPTH - 1; i++) wr(A_TXD, 32'h10 + i);
    rd(A_STAT, d); chk("R3 not full at DEPTH-1", {31'd0, d[3]}, 32'd0);
    wr(A_TXD, 32'h10 + DEPTH - 1);
    rd(A_STAT, d); chk("R3 full at DEPTH", {31'd0, d[3]}, 32'd1);
    wr(A_TXD, 32'h99);
    chk("R3 overflow pulse", {31'd0, evt_tx_overflow}, 32'd1);
    base = m_edges;
    repeat (20) @(negedge clk); #1;
    chk("R4 hold keeps sck still", m_edges - base, 0);
    wr(A_CTRL, C_EN | C_MST | C_LOOP);
    repeat (2 * W * DEPTH * DIV + 1) @(negedge clk); #1;
    chk("R4 one edge short before last", m_edges - base, 2 * W * DEPTH - 1);
    @(negedge clk); #1;
    chk("R4 back-to-back burst", m_edges - base, 2 * W * DEPTH);
    wait_done();
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, d); chk("R4 burst order", d, 32'h10 + i);
    end
    rd(A_STAT, d); chk("R3 dropped word absent", {31'd0, d[0]}, 32'd1);

    // R9: done flag waits for the shifter
    wr(A_TXD, 32'h6B);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R9 done clear while shifting", {31'd0, d[2]}, 32'd0);
    wait_done();
    rd(A_RXD, d); chk("R9 word ready at done", d, 32'h6B);

    // R10: overrun
    wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD);
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'h21 + i);
    wr(A_CTRL, C_EN | C_MST | C_LOOP);
    wait_done();
    rd(A_STAT, d); chk("R10 rx full status", d, 32'h6);
    base = m_ovr;
    wr(A_TXD, 32'h55); wait_done();
    repeat (2) @(negedge clk); #1;
    chk("R10 overrun pulse", m_ovr - base, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, d); chk("R10 kept words", d, 32'h21 + i);
    end
    rd(A_STAT, d); chk("R10 extra word dropped", {31'd0, d[0]}, 32'd1);

    // R11: slave select modes
    wr(A_SSEL, 32'hA);
    wr(A_CTRL, C_EN | C_MST | C_MAN);
    #1 chk("R11 manual follows reg", {28'd0, ss_n}, 32'hA);
    wr(A_SSEL, 32'hE);
    wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD);
    #1 chk("R11 auto idle deselect", {28'd0, ss_n}, 32'hF);
    wr(A_TXD, 32'h3A);
    wr(A_CTRL, C_EN | C_MST | C_LOOP);
    repeat (4) @(negedge clk); #1;
    chk("R11 auto select while shifting", {28'd0, ss_n}, 32'hE);
    wait_done();
    #1 chk("R11 auto deselect after", {28'd0, ss_n}, 32'hF);
    rd(A_RXD, d);

    // R13: enable / master gate
    base = m_edges;
    wr(A_CTRL, C_MST | C_LOOP);
    wr(A_TXD, 32'h77);
    repeat (30) @(negedge clk);
    wr(A_CTRL, C_EN | C_LOOP);
    repeat (30) @(negedge clk); #1;
    chk("R13 no shifting when gated", m_edges - base, 0);
    rd(A_STAT, d); chk("R13 word still queued", {31'd0, d[2]}, 32'd0);

    // R14: FIFO clear strobes
    wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD | C_TXR);
    rd(A_STAT, d); chk("R14 tx cleared", d, 32'h5);
    wr(A_CTRL, C_EN | C_MST | C_LOOP);
    repeat (30) @(negedge clk); #1;
    chk("R14 nothing left to send", m_edges - base, 0);
    wr(A_TXD, 32'h44); wait_done();
    rd(A_STAT, d); chk("R14 rx holds word", {31'd0, d[0]}, 32'd0);
    wr(A_CTRL, C_EN | C_MST | C_LOOP | C_RXR);
    rd(A_STAT, d); chk("R14 rx cleared", {31'd0, d[0]}, 32'd1);
    rd(A_CTRL, d); chk("R2 strobe bits read zero", d, C_EN | C_MST | C_LOOP);

    summary();
  end
endmodule